// File: doc/BRIEF.md
# Predicated Execution Datapath Unit

This unit is the execute and retire back end of a small toy processor. Each cycle it takes one decoded instruction. It computes the result with operands from a general register file. It then retires the instruction one cycle later. The unit has two architectural stores: sixteen 32-bit general registers and sixteen one-bit predicates. Guarded instructions always compute their result. Only the final register write is enabled or blocked, and this is decided at retire.

A compare-equal instruction writes an even/odd predicate pair in one step. The even member gets the equality result and the odd member gets its inverse. A following then-block and else-block can therefore each be guarded by one member of the pair, and no branch is needed. Conditional moves do not use a predicate. They test a general register for zero or nonzero. A retire port reports, every cycle, what was committed. Debug read ports expose both register files.

Top module: `pred_exec_unit`

## Requirements
- R1: After synchronous reset, every general register reads 0, predicate 0 reads 1, all other predicates read 0, and `ret_valid` is low.
- R2: The op encoding is 0 NOP, 1 ADD, 2 SUB, 3 MOV, 4 CMPEQ, 5 CMOVZ, 6 CMOVN, 7 MOVI. An accepted non-NOP instruction appears on the retire port in the second cycle after the edge that accepts it. When its guard is true, the destination write is reported on the retire port and is visible on the debug port one cycle later.
- R3: ADD, SUB, MOV and MOVI are guarded by predicate `in_pr`. Their results are, in order: `ra+rb` modulo 2^32, `ra-rb` modulo 2^32, `ra`, and `in_imm`. When the guard is true, `ret_wen` is 1 and `ret_data` carries the result.
- R4: When the guard predicate of ADD, SUB, MOV or MOVI is 0, the instruction still retires with its computed result on `ret_data`, but `ret_wen` is 0 and the destination keeps its old value.
- R5: CMPEQ compares `ra` with `rb`. It writes predicate 2k with the equality result and predicate 2k+1 with the inverse, where k is `in_pr` with bit 0 dropped. It reports `ret_pwe`=1, `ret_pidx`=2k, and `ret_data` equal to the equality flag. It never writes a general register.
- R6: A CMPEQ that selects pair 0 (`in_pr` 0 or 1) changes no predicate and reports `ret_pwe`=0. Predicate 1 therefore always reads 0, and predicate 0 always reads 1.
- R7: CMOVZ copies `ra` to `rd` only when register `rb` is zero. CMOVN copies only when `rb` is nonzero. When the test fails, `ret_wen` is 0 and `rd` is unchanged, even when `rd` equals `ra`.
- R8: An instruction accepted in the cycle right after another one sees that instruction's committed register result, and, when guarded, sees a predicate pair that instruction wrote.
- R9: NOP and idle cycles never produce a retire, and `ret_wen` or `ret_pwe` are never high without `ret_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation code |
| in_rd | input | 4 | Destination register |
| in_ra | input | 4 | First source register |
| in_rb | input | 4 | Second source, or test register for conditional moves |
| in_pr | input | 4 | Guard predicate, or target pair for CMPEQ |
| in_imm | input | 32 | Immediate for MOVI |
| dbg_gidx | input | 4 | Debug general register select |
| dbg_gdata | output | 32 | Debug general register value |
| dbg_pidx | input | 4 | Debug predicate select |
| dbg_pdata | output | 1 | Debug predicate value |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_wen | output | 1 | Retiring instruction writes a general register |
| ret_dst | output | 4 | Destination of the retiring instruction |
| ret_data | output | 32 | Computed result, reported whether or not it is written |
| ret_pwe | output | 1 | Retiring compare writes a predicate pair |
| ret_pidx | output | 4 | Even index of the predicate pair written |

## Verification
The arithmetic ops are run with a true guard, a false guard and a guard on the constant-zero predicate. This separates write gating from computation, because the blocked result must still show on the retire port. Compares are run with equal and unequal operands, with an odd target index and with pair 0. These cases separate correct pair placement and inversion from wrong index use, and show whether the pair-0 block works. Conditional moves are run with zero and nonzero test values, including a failing move onto its own source register. Back-to-back dependent instructions show whether register forwarding and retire-time predicate reads are present.

// File: rtl/pred_exec_pkg.sv
package pred_exec_pkg;

    localparam int XLEN = 32;
    localparam int NGPR = 16;
    localparam int NPRD = 16;
    localparam int GIW  = $clog2(NGPR);
    localparam int PIW  = $clog2(NPRD);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [GIW-1:0]  gidx_t;
    typedef logic [PIW-1:0]  pidx_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_MOV   = 3'd3,
        OP_CMPEQ = 3'd4,
        OP_CMOVZ = 3'd5,
        OP_CMOVN = 3'd6,
        OP_MOVI  = 3'd7
    } op_e;

    // Instruction held in the execute stage
    typedef struct packed {
        logic  vld;
        op_e   op;
        gidx_t rd;
        gidx_t ra;
        gidx_t rb;
        pidx_t pr;
        word_t imm;
    } ex_slot_t;

    // Computed instruction waiting for its commit decision
    typedef struct packed {
        logic  vld;
        op_e   op;
        gidx_t rd;
        pidx_t pr;
        word_t res;
        logic  cond_ok;
    } rt_slot_t;

    function automatic logic op_is_guarded(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV) || (op == OP_MOVI);
    endfunction

    function automatic logic op_is_cmov(op_e op);
        return (op == OP_CMOVZ) || (op == OP_CMOVN);
    endfunction

endpackage

// File: rtl/pe_gpr_file.sv
module pe_gpr_file #(
    parameter int W   = pred_exec_pkg::XLEN,
    parameter int N   = pred_exec_pkg::NGPR,
    parameter int NRD = 3,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [W-1:0]           wr_data,
    input  logic [NRD-1:0][IW-1:0] rd_idx,
    output logic [NRD-1:0][W-1:0]  rd_data,
    output logic [N-1:0][W-1:0]    regs_o
);
    logic [N-1:0][W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (wr_idx == IW'(i))) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = regs_q[rd_idx[r]];
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/pe_pred_file.sv
module pe_pred_file #(
    parameter int N   = pred_exec_pkg::NPRD,
    parameter int NRD = 2,
    localparam int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IW-2:0]          wr_pair,
    input  logic                   wr_eq,
    input  logic [NRD-1:0][IW-1:0] rd_idx,
    output logic [NRD-1:0]         rd_val,
    output logic [N-1:0]           flags_o
);
    // Pair 0 is constant: index 0 is always true, index 1 always false
    logic [N-1:2] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (wr_en && (wr_pair != '0)) begin
            store_q[{wr_pair, 1'b0}] <= wr_eq;
            store_q[{wr_pair, 1'b1}] <= !wr_eq;
        end
    end

    assign flags_o = {store_q, 2'b01};

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_val[r] = flags_o[rd_idx[r]];
    end
endmodule

// File: rtl/pe_exec.sv
module pe_exec
    import pred_exec_pkg::*;
(
    input  ex_slot_t ex_i,
    input  word_t    opa_i,
    input  word_t    opb_i,
    output rt_slot_t rt_o
);
    word_t res;
    logic  ok;

    always_comb begin
        res = '0;
        ok  = 1'b1;
        unique case (ex_i.op)
            OP_ADD:   res = opa_i + opb_i;
            OP_SUB:   res = opa_i - opb_i;
            OP_MOV:   res = opa_i;
            OP_MOVI:  res = ex_i.imm;
            OP_CMPEQ: res = word_t'(opa_i == opb_i);
            OP_CMOVZ: begin
                res = opa_i;
                ok  = (opb_i == '0);
            end
            OP_CMOVN: begin
                res = opa_i;
                ok  = (opb_i != '0);
            end
            default:  res = '0;
        endcase
    end

    assign rt_o = '{vld: ex_i.vld, op: ex_i.op, rd: ex_i.rd, pr: ex_i.pr,
                    res: res, cond_ok: ok};
endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
    import pred_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [2:0]  in_op,
    input  logic [3:0]  in_rd,
    input  logic [3:0]  in_ra,
    input  logic [3:0]  in_rb,
    input  logic [3:0]  in_pr,
    input  logic [31:0] in_imm,
    input  logic [3:0]  dbg_gidx,
    output logic [31:0] dbg_gdata,
    input  logic [3:0]  dbg_pidx,
    output logic        dbg_pdata,
    output logic        ret_valid,
    output logic        ret_wen,
    output logic [3:0]  ret_dst,
    output logic [31:0] ret_data,
    output logic        ret_pwe,
    output logic [3:0]  ret_pidx
);
    ex_slot_t ex_q, ex_d;
    rt_slot_t rt_q, rt_d;

    logic [2:0][GIW-1:0]  g_ridx;
    logic [2:0][XLEN-1:0] g_rdat;
    logic [NGPR-1:0][XLEN-1:0] gpr_view;
    logic [1:0][PIW-1:0]  p_ridx;
    logic [1:0]           p_rval;
    logic [NPRD-1:0]      pred_view;
    word_t opa, opb;
    logic  guard;

    // Accept stage
    always_comb begin
        ex_d.vld = in_valid && (op_e'(in_op) != OP_NOP);
        ex_d.op  = op_e'(in_op);
        ex_d.rd  = in_rd;
        ex_d.ra  = in_ra;
        ex_d.rb  = in_rb;
        ex_d.pr  = in_pr;
        ex_d.imm = in_imm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q <= '0;
            rt_q <= '0;
        end else begin
            ex_q <= ex_d;
            rt_q <= rt_d;
        end
    end

    // Register reads for execute, plus the debug port
    assign g_ridx = {dbg_gidx, ex_q.rb, ex_q.ra};

    pe_gpr_file #(.W(XLEN), .N(NGPR), .NRD(3)) u_gpr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ret_wen),
        .wr_idx  (ret_dst),
        .wr_data (ret_data),
        .rd_idx  (g_ridx),
        .rd_data (g_rdat),
        .regs_o  (gpr_view)
    );

    // Forward the commit in flight to the instruction behind it
    assign opa = (ret_wen && (ret_dst == ex_q.ra)) ? ret_data : g_rdat[0];
    assign opb = (ret_wen && (ret_dst == ex_q.rb)) ? ret_data : g_rdat[1];

    pe_exec u_exec (
        .ex_i  (ex_q),
        .opa_i (opa),
        .opb_i (opb),
        .rt_o  (rt_d)
    );

    // Retire: the guard predicate is read here, from the committed file
    assign p_ridx = {dbg_pidx, rt_q.pr};

    pe_pred_file #(.N(NPRD), .NRD(2)) u_pred (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ret_pwe),
        .wr_pair (rt_q.pr[PIW-1:1]),
        .wr_eq   (rt_q.res[0]),
        .rd_idx  (p_ridx),
        .rd_val  (p_rval),
        .flags_o (pred_view)
    );

    always_comb begin
        if (op_is_guarded(rt_q.op))   guard = p_rval[0];
        else if (op_is_cmov(rt_q.op)) guard = rt_q.cond_ok;
        else                          guard = 1'b0;
    end

    assign ret_valid = rt_q.vld;
    assign ret_wen   = rt_q.vld && guard;
    assign ret_dst   = rt_q.rd;
    assign ret_data  = rt_q.res;
    assign ret_pwe   = rt_q.vld && (rt_q.op == OP_CMPEQ) && (rt_q.pr[PIW-1:1] != '0);
    assign ret_pidx  = {rt_q.pr[PIW-1:1], 1'b0};

    assign dbg_gdata = g_rdat[2];
    assign dbg_pdata = p_rval[1];
endmodule

// File: rtl/pred_exec_chk.sv
module pred_exec_chk (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic              ret_valid,
    input logic              ret_wen,
    input logic [3:0]        ret_dst,
    input logic [31:0]       ret_data,
    input logic              ret_pwe,
    input logic [3:0]        ret_pidx,
    input logic [15:0][31:0] gregs,
    input logic [15:0]       pflags
);
    // R2
    retire_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op != 3'd0)) |=> ##1 ret_valid);

    // R2
    commit_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ret_wen |=> (gregs[$past(ret_dst)] == $past(ret_data)));

    // R4
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        !ret_wen |=> $stable(gregs));

    // R5
    pair_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        ret_pwe |=> (pflags[$past(ret_pidx)] != pflags[$past(ret_pidx) + 4'd1]));

    // R6
    pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ret_pwe |=> $stable(pflags));

    // R9
    wen_needs_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_wen || ret_pwe) |-> ret_valid);

    // R9
    one_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !(ret_wen && ret_pwe));
endmodule

bind pred_exec_unit pred_exec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .ret_valid (ret_valid),
    .ret_wen   (ret_wen),
    .ret_dst   (ret_dst),
    .ret_data  (ret_data),
    .ret_pwe   (ret_pwe),
    .ret_pidx  (ret_pidx),
    .gregs     (gpr_view),
    .pflags    (pred_view)
);

// File: tb/pred_exec_unit_tb.sv
module pred_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [3:0]  in_rd = '0, in_ra = '0, in_rb = '0, in_pr = '0;
    logic [31:0] in_imm = '0;
    logic [3:0]  dbg_gidx = '0, dbg_pidx = '0;
    logic [31:0] dbg_gdata;
    logic        dbg_pdata;
    logic        ret_valid, ret_wen, ret_pwe;
    logic [3:0]  ret_dst, ret_pidx;
    logic [31:0] ret_data;

    always #2.5 clk = ~clk;

    pred_exec_unit u_dut (.*);

    typedef struct {
        string       tag;
        logic        wen;
        logic [3:0]  dst;
        logic [31:0] data;
        logic        pwe;
        logic [3:0]  pidx;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mg[16];
    logic        mp[16];
    int          total = 0;
    int          bad   = 0;
    logic        done  = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one instruction per call, reference model in program order
    task automatic issue(string tag, logic [2:0] op, logic [3:0] rd, logic [3:0] ra,
                         logic [3:0] rb, logic [3:0] pr, logic [31:0] imm);
        exp_t        e;
        logic [31:0] a, b;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_rd = rd; in_ra = ra;
        in_rb = rb; in_pr = pr; in_imm = imm;
        a = mg[ra]; b = mg[rb];
        e.tag = tag; e.dst = rd; e.wen = 1'b0; e.pwe = 1'b0;
        e.pidx = {pr[3:1], 1'b0}; e.data = '0;
        case (op)
            3'd1: begin e.data = a + b; e.wen = mp[pr]; end
            3'd2: begin e.data = a - b; e.wen = mp[pr]; end
            3'd3: begin e.data = a;     e.wen = mp[pr]; end
            3'd7: begin e.data = imm;   e.wen = mp[pr]; end
            3'd4: begin e.data = {31'd0, a == b}; e.pwe = (pr[3:1] != 3'd0); end
            3'd5: begin e.data = a; e.wen = (b == 0); end
            3'd6: begin e.data = a; e.wen = (b != 0); end
            default: ;
        endcase
        if (op != 3'd0) begin
            exp_q.push_back(e);
            if (e.wen) mg[rd] = e.data;
            if (e.pwe) begin
                mp[e.pidx]      = (a == b);
                mp[e.pidx + 1]  = (a != b);
            end
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 3'd7;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare whenever an instruction retires
    always @(negedge clk) begin
        if (!rst && ret_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9", "spurious retire", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "ret_wen", {31'd0, ret_wen}, {31'd0, e.wen});
                chk(e.tag, "ret_pwe", {31'd0, ret_pwe}, {31'd0, e.pwe});
                chk(e.tag, "ret_data", ret_data, e.data);
                if (e.wen) chk(e.tag, "ret_dst", {28'd0, ret_dst}, {28'd0, e.dst});
                if (e.pwe) chk(e.tag, "ret_pidx", {28'd0, ret_pidx}, {28'd0, e.pidx});
            end
        end
    end

    task automatic dump_compare(string tag);
        for (int i = 0; i < 16; i++) begin
            dbg_gidx = 4'(i); dbg_pidx = 4'(i);
            #1;
            chk(tag, $sformatf("gpr%0d", i), dbg_gdata, mg[i]);
            chk(tag, $sformatf("pred%0d", i), {31'd0, dbg_pdata}, {31'd0, mp[i]});
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mg[i] = '0;
            mp[i] = (i == 0);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset contents and no retire
        chk("R1", "ret_valid", {31'd0, ret_valid}, 32'd0);
        dump_compare("R1");

        // R3: immediates and a back-to-back burst
        issue("R3", 3'd7, 4'd1, 4'd0, 4'd0, 4'd0, 32'd5);
        issue("R3", 3'd7, 4'd2, 4'd0, 4'd0, 4'd0, 32'd5);
        issue("R3", 3'd7, 4'd3, 4'd0, 4'd0, 4'd0, 32'd7);
        issue("R3", 3'd7, 4'd4, 4'd0, 4'd0, 4'd0, 32'hFFFF_FFFF);
        // R5 equal pair 2/3, then R8 guards read it the next cycle
        issue("R5", 3'd4, 4'd0, 4'd1, 4'd2, 4'd2, 32'd0);
        issue("R8", 3'd1, 4'd5, 4'd1, 4'd3, 4'd2, 32'd0);
        issue("R4", 3'd2, 4'd6, 4'd1, 4'd3, 4'd3, 32'd0);
        // R5 unequal with odd target index -> pair 4/5
        issue("R5", 3'd4, 4'd0, 4'd1, 4'd3, 4'd5, 32'd0);
        issue("R3", 3'd1, 4'd7, 4'd4, 4'd3, 4'd5, 32'd0);
        issue("R4", 3'd3, 4'd8, 4'd3, 4'd0, 4'd4, 32'd0);
        // R6 pair 0 cannot be written
        issue("R6", 3'd4, 4'd0, 4'd1, 4'd3, 4'd1, 32'd0);
        issue("R6", 3'd4, 4'd0, 4'd1, 4'd2, 4'd0, 32'd0);
        issue("R4", 3'd1, 4'd9, 4'd1, 4'd1, 4'd1, 32'd0);
        idle(3);
        // R7 conditional moves
        issue("R7", 3'd5, 4'd9, 4'd3, 4'd10, 4'd0, 32'd0);
        issue("R7", 3'd6, 4'd9, 4'd1, 4'd10, 4'd0, 32'd0);
        issue("R7", 3'd6, 4'd11, 4'd1, 4'd3, 4'd0, 32'd0);
        issue("R7", 3'd5, 4'd3, 4'd3, 4'd1, 4'd0, 32'd0);
        // R9 a NOP in the stream
        issue("R9", 3'd0, 4'd12, 4'd1, 4'd1, 4'd0, 32'd0);
        // R8 register dependency chain
        issue("R8", 3'd1, 4'd12, 4'd5, 4'd5, 4'd0, 32'd0);
        issue("R8", 3'd1, 4'd13, 4'd12, 4'd12, 4'd0, 32'd0);
        issue("R8", 3'd5, 4'd14, 4'd13, 4'd15, 4'd0, 32'd0);
        // R8 compare flips pair 2/3, guards follow immediately
        issue("R8", 3'd4, 4'd0, 4'd1, 4'd3, 4'd3, 32'd0);
        issue("R8", 3'd7, 4'd15, 4'd0, 4'd0, 4'd3, 32'hA5A5_0001);
        issue("R8", 3'd7, 4'd10, 4'd0, 4'd0, 4'd2, 32'h0000_BEEF);
        idle(5);
        chk("R9", "queue drained", exp_q.size(), 32'd0);
        // R2 final state through the debug ports
        dump_compare("R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule